// File: doc/BRIEF.md
# Receive FIFO with threshold flag

This block buffers received words from a serial audio deserializer in an eight-entry first-in first-out store. Software or a DMA engine reads them one at a time through a register-style pop strobe. The head word is always visible on the read data port, and each strobe retires it.

A two-bit trigger select sets a fill threshold. Once the stored count reaches that threshold, a sticky ready flag rises, and the interrupt/DMA request follows it. The flag is clear-only. A write of zero removes it, but only while the count sits below the threshold. A write of one does nothing. The live count and a sticky overflow indication are exported, and a FIFO clear input empties the store.

Top module: `rx_thresh_fifo`

## Requirements
- R1: After reset the count is 0, and the ready flag, the request and the overflow bit are all 0.
- R2: Words leave in the order they were accepted, and the count tracks accepted pushes minus effective pops. The head word is visible on rd_data_o before its pop strobe.
- R3: A push while 8 words are held is dropped and sets the overflow bit. The stored words are unchanged. The overflow bit stays set until a FIFO clear.
- R4: A pop strobe with an empty store leaves the count at 0, and a later push/pop pair still returns the pushed word.
- R5: Trigger select values 0, 1, 2 and 3 give thresholds of 1, 2, 4 and 6 words. The flag goes to 1 on the edge after the one at which the count is equal to or above the threshold.
- R6: A clear request (flag_wr_i with flag_wdata_i = 0) is ignored while the count is at or above the threshold.
- R7: A clear request while the count is below the threshold drops the flag to 0 on that edge.
- R8: A flag write with flag_wdata_i = 1 has no effect on the flag.
- R9: A FIFO clear sets the count to 0, discards the stored words and clears the overflow bit. It leaves the ready flag unchanged.
- R10: req_o is 1 exactly when the ready flag is 1.
- R11: A push and a pop in the same cycle on a non-empty, non-full store leave the count unchanged and return the head word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Received word is valid this cycle |
| wr_data_i | input | DW | Received word |
| rd_strobe_i | input | 1 | Pop strobe from the register read |
| rd_data_o | output | DW | Head word |
| trig_sel_i | input | 2 | Threshold select (0..3 gives 1, 2, 4, 6) |
| fifo_clr_i | input | 1 | Empties the store and clears overflow |
| flag_wr_i | input | 1 | Status write strobe for the ready flag |
| flag_wdata_i | input | 1 | Value written to the ready flag |
| ready_o | output | 1 | Sticky threshold flag |
| req_o | output | 1 | Interrupt/DMA request |
| count_o | output | CW | Stored word count |
| overflow_o | output | 1 | Sticky overflow indication |

## Verification
The bench targets the places where the flag and the count interact:
- A clear request at exactly the threshold is probed. A design that compares with "greater than" would clear the flag early and lose a DMA burst.
- Clears below the threshold and writes of one are probed. A design that treats the write as a plain store would raise the flag spuriously or never release it.
- Each trigger encoding is probed at one below and exactly at its threshold.
- Overflow is probed with pushes into a full store. A design that let these pushes through would overwrite the oldest word or wrap the count.
- Pops on an empty store are probed. A design that did not guard them would corrupt the pointers and hand back stale words.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0: return 1;
      2'd1: return 2;
      2'd2: return 4;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 16,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [DW-1:0] din_i,
  input  logic          pop_i,
  input  logic          clr_i,
  output logic [DW-1:0] dout_o,
  output logic [CW-1:0] count_o,
  output logic          ovf_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam bit POW2 = (DEPTH == (1 << AW));

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_nx, rd_ptr_nx;
  logic [CW-1:0] count_q;
  logic          ovf_q, full, empty, do_push, do_pop;

  assign full    = (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign do_push = push_i & ~full;
  assign do_pop  = pop_i & ~empty;

  generate
    if (POW2) begin : g_wrap_nat
      assign wr_ptr_nx = wr_ptr_q + 1'b1;
      assign rd_ptr_nx = rd_ptr_q + 1'b1;
    end else begin : g_wrap_cmp
      assign wr_ptr_nx = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      assign rd_ptr_nx = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovf_q    <= 1'b0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_nx;
      if (do_pop)  rd_ptr_q <= rd_ptr_nx;
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (push_i && full) ovf_q <= 1'b1;
    end
  end

  // data array carries no reset
  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_ptr_q] <= din_i;
  end

  assign dout_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/rxf_flag.sv
module rxf_flag #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic [1:0]    trig_sel_i,
  input  logic          wr_i,
  input  logic          wdata_i,
  output logic          flag_o
);
  logic [CW:0] level;
  logic        at_lvl, clr_ok, flag_q;

  assign level  = (CW+1)'(rxf_pkg::trig_level(trig_sel_i));
  assign at_lvl = ({1'b0, count_i} >= level);
  // zero-write only lands once occupancy is under the threshold
  assign clr_ok = wr_i & ~wdata_i & ~at_lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= at_lvl | (flag_q & ~clr_ok);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rx_thresh_fifo.sv
module rx_thresh_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 16,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_strobe_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [1:0]    trig_sel_i,
  input  logic          fifo_clr_i,
  input  logic          flag_wr_i,
  input  logic          flag_wdata_i,
  output logic          ready_o,
  output logic          req_o,
  output logic [CW-1:0] count_o,
  output logic          overflow_o
);
  logic [CW-1:0] count;
  logic          flag;

  rxf_store #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (wr_valid_i),
    .din_i   (wr_data_i),
    .pop_i   (rd_strobe_i),
    .clr_i   (fifo_clr_i),
    .dout_o  (rd_data_o),
    .count_o (count),
    .ovf_o   (overflow_o)
  );

  rxf_flag #(.CW(CW)) i_flag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .count_i    (count),
    .trig_sel_i (trig_sel_i),
    .wr_i       (flag_wr_i),
    .wdata_i    (flag_wdata_i),
    .flag_o     (flag)
  );

  assign count_o = count;
  assign ready_o = flag;
  assign req_o   = flag;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_valid_i,
  input logic          rd_strobe_i,
  input logic [1:0]    trig_sel_i,
  input logic          fifo_clr_i,
  input logic          flag_wr_i,
  input logic          flag_wdata_i,
  input logic          ready_o,
  input logic [CW-1:0] count_o,
  input logic          overflow_o
);
  logic at_lvl;
  assign at_lvl = ({1'b0, count_o} >= (CW+1)'(rxf_pkg::trig_level(trig_sel_i)));

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH)); // R2
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !fifo_clr_i |=> overflow_o); // R3
  AST_EMPTY_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o == '0 && rd_strobe_i && !wr_valid_i |=> count_o == '0); // R4
  AST_FLAG_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_lvl |=> ready_o); // R5
  AST_CLEAR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && flag_wr_i && !flag_wdata_i && at_lvl |=> ready_o); // R6
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_wr_i && !flag_wdata_i && !at_lvl |=> !ready_o); // R7
  AST_ONE_WRITE_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o && !at_lvl && flag_wr_i && flag_wdata_i |=> !ready_o); // R8
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_i |=> count_o == '0 && !overflow_o); // R9
endmodule

bind rx_thresh_fifo rxf_checker #(.DEPTH(DEPTH), .CW(CW)) i_rxf_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_valid_i   (wr_valid_i),
  .rd_strobe_i  (rd_strobe_i),
  .trig_sel_i   (trig_sel_i),
  .fifo_clr_i   (fifo_clr_i),
  .flag_wr_i    (flag_wr_i),
  .flag_wdata_i (flag_wdata_i),
  .ready_o      (ready_o),
  .count_o      (count_o),
  .overflow_o   (overflow_o)
);

// File: tb/test_rx_thresh_fifo.sv
`timescale 1ns/1ps
module test_rx_thresh_fifo;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned DW    = 16;
  localparam int unsigned CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_valid_i = 1'b0;
  logic [DW-1:0] wr_data_i = '0;
  logic          rd_strobe_i = 1'b0;
  logic [DW-1:0] rd_data_o;
  logic [1:0]    trig_sel_i = 2'd0;
  logic          fifo_clr_i = 1'b0;
  logic          flag_wr_i = 1'b0;
  logic          flag_wdata_i = 1'b0;
  logic          ready_o, req_o, overflow_o;
  logic [CW-1:0] count_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  rx_thresh_fifo #(.DEPTH(DEPTH), .DW(DW)) i_rx_thresh_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
    .rd_strobe_i(rd_strobe_i), .rd_data_o(rd_data_o), .trig_sel_i(trig_sel_i),
    .fifo_clr_i(fifo_clr_i), .flag_wr_i(flag_wr_i), .flag_wdata_i(flag_wdata_i),
    .ready_o(ready_o), .req_o(req_o), .count_o(count_o), .overflow_o(overflow_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: push word, scoreboard records it if space is modelled
  task automatic push(input logic [DW-1:0] d);
    wr_valid_i = 1'b1; wr_data_i = d;
    if (exp_q.size() < DEPTH) exp_q.push_back(d);
    @(negedge clk);
    wr_valid_i = 1'b0;
  endtask

  // monitor: compare head against scoreboard, then retire it
  task automatic pop(input string req);
    if (exp_q.size() > 0) chk(req, int'(rd_data_o), int'(exp_q.pop_front()));
    rd_strobe_i = 1'b1;
    @(negedge clk);
    rd_strobe_i = 1'b0;
  endtask

  task automatic flag_write(input logic v);
    flag_wr_i = 1'b1; flag_wdata_i = v;
    @(negedge clk);
    flag_wr_i = 1'b0;
  endtask

  task automatic fifo_clear();
    fifo_clr_i = 1'b1;
    exp_q.delete();
    @(negedge clk);
    fifo_clr_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int lv [4] = '{1, 2, 4, 6};
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    chk("R1 count", count_o, 0);
    chk("R1 ready", ready_o, 0);
    chk("R1 req", req_o, 0);
    chk("R1 overflow", overflow_o, 0);

    // threshold 4
    trig_sel_i = 2'd2;
    for (int i = 0; i < 3; i++) push(DW'(16'h100 + i));
    idle(2);
    chk("R5 below level", ready_o, 0);
    push(16'h103);
    idle(1);
    chk("R5 at level", ready_o, 1);
    chk("R10 req follows", req_o, 1);
    chk("R2 count", count_o, 4);

    flag_write(1'b0);
    idle(1);
    chk("R6 clear at level ignored", ready_o, 1);

    pop("R2 order");
    chk("R2 count after pop", count_o, 3);
    flag_write(1'b1);
    chk("R8 one-write keeps 1", ready_o, 1);
    flag_write(1'b0);
    chk("R7 clear below level", ready_o, 0);
    chk("R10 req drops", req_o, 0);
    flag_write(1'b1);
    idle(1);
    chk("R8 one-write keeps 0", ready_o, 0);

    // R11 simultaneous push and pop
    wr_valid_i = 1'b1; wr_data_i = 16'h200; exp_q.push_back(16'h200);
    chk("R11 head", int'(rd_data_o), int'(exp_q.pop_front()));
    rd_strobe_i = 1'b1;
    idle(1);
    wr_valid_i = 1'b0; rd_strobe_i = 1'b0;
    chk("R11 count kept", count_o, 3);

    while (exp_q.size() > 0) pop("R2 order");
    chk("R2 drained", count_o, 0);

    // R4 empty pop
    rd_strobe_i = 1'b1;
    idle(2);
    rd_strobe_i = 1'b0;
    chk("R4 count stays 0", count_o, 0);
    push(16'h0abc);
    chk("R4 count after push", count_o, 1);
    pop("R4 data after empty pop");
    chk("R4 count back to 0", count_o, 0);

    // R5 each trigger encoding
    for (int s = 0; s < 4; s++) begin
      trig_sel_i = 2'(s);
      fifo_clear();
      flag_write(1'b0);
      for (int i = 0; i < lv[s] - 1; i++) push(DW'(16'h300 + i));
      idle(2);
      chk("R5 one below level", ready_o, 0);
      push(16'h3ff);
      idle(1);
      chk("R5 reaches level", ready_o, 1);
    end

    // R3 overflow with threshold 6
    fifo_clear();
    for (int i = 0; i < DEPTH; i++) push(DW'(16'h400 + i));
    chk("R3 full count", count_o, DEPTH);
    chk("R3 no overflow yet", overflow_o, 0);
    push(16'hdead);
    push(16'hbeef);
    chk("R3 overflow set", overflow_o, 1);
    chk("R3 count held", count_o, DEPTH);
    while (exp_q.size() > 0) pop("R3 contents intact");
    chk("R3 overflow sticky", overflow_o, 1);
    chk("R3 drained", count_o, 0);

    // R9 clear
    push(16'h500);
    push(16'h501);
    fifo_clear();
    chk("R9 count cleared", count_o, 0);
    chk("R9 overflow cleared", overflow_o, 0);
    chk("R9 flag kept", ready_o, 1);
    push(16'h600);
    pop("R9 old data discarded");
    flag_write(1'b0);
    chk("R9 flag cleared by write after clear", ready_o, 0);

    idle(2);
    finish_run();
  end
endmodule